// File: doc/BRIEF.md
# Scratchpad Register File with Selectable Address Source

The block is a small scratchpad: sixteen words of sixteen bits, held in flops, with one write-data bus and one read-data bus. Four clients each present their own 4-bit word address at the same time. A one-hot select vector decides which of those four addresses reaches the array in a given cycle. The chosen address serves both the write port and the read port.

Writes happen on the rising clock edge, and each byte lane has its own strobe. This lets a client update either half of a word without touching the other half. Reads are combinational from the selected word. An output-enable input can hold the read bus at zero.

If the select vector is not exactly one-hot, the block falls back to the first address field. It also raises an error flag, which lets the surrounding control logic detect a conflicting or missing selection.

Top module: `sp_regfile`

## Requirements
- R1: A synchronous active-high reset clears all sixteen words to zero.
- R2: On a rising clock edge, the word at the selected address takes `wdata` in each lane whose strobe is set. `lane_we[1]` covers bits 15..8 and `lane_we[0]` covers bits 7..0.
- R3: A lane whose strobe is low keeps its previous contents. With both strobes low, no word changes.
- R4: The read is combinational. When the selected address or the select vector changes, `rdata` shows the newly addressed word with no clock edge in between.
- R5: When `set_sel` is one-hot with bit k set, the address is `addr_sets[4k+3:4k]`. Field 0 (bits 3..0) is set A.
- R6: When `set_sel` has zero bits set or more than one bit set, the address is taken from field 0 and `sel_err` is 1. Otherwise `sel_err` is 0.
- R7: When `out_en` is 0, `rdata` is all zeros. `out_en` has no effect on writes.
- R8: A write is visible on `rdata` right after the clock edge that performs it, with the same address selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sets | input | 16 | Four packed 4-bit word addresses; field k at bits 4k+3..4k |
| set_sel | input | 4 | One-hot choice of the address field |
| lane_we | input | 2 | Byte-lane write strobes (bit 1 upper, bit 0 lower) |
| wdata | input | 16 | Write data |
| out_en | input | 1 | Read output enable; 0 forces `rdata` to zero |
| rdata | output | 16 | Read data of the selected word |
| sel_err | output | 1 | Select vector not one-hot; field 0 in use |

## Verification
The hardest case to reach is a malformed select vector that lands on a word which differs from the word the other fields point at. Only that case tells the field-0 fallback apart from an OR-merge or a priority pick among the asserted bits. The stimulus first fills every word with a distinct value. It then sweeps all sixteen select codes while each address field holds a different address. This way each code reads a word that only the correct routing could produce. Lane-only writes follow, and their readback shows whether the untouched half survived.

// File: rtl/scratch_pkg.sv
package scratch_pkg;

    parameter int WORD_W = 16;
    parameter int LANE_W = 8;
    parameter int DEPTH  = 16;
    parameter int N_SETS = 4;

    localparam int N_LANES = WORD_W / LANE_W;
    localparam int ADDR_W  = $clog2(DEPTH);
    localparam int SETS_W  = N_SETS * ADDR_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [ADDR_W-1:0]  addr_t;
    typedef logic [N_LANES-1:0] lane_t;
    typedef logic [N_SETS-1:0]  sel_t;

    typedef struct packed {
        addr_t addr;
        logic  err;
    } route_t;

    typedef struct packed {
        logic  en;
        addr_t addr;
        word_t data;
        word_t mask;
    } wreq_t;

    function automatic word_t lane_to_mask(lane_t l);
        word_t m;
        for (int i = 0; i < N_LANES; i++) begin
            m[i*LANE_W +: LANE_W] = {LANE_W{l[i]}};
        end
        return m;
    endfunction

    function automatic logic is_onehot(sel_t s);
        int n;
        n = 0;
        for (int i = 0; i < N_SETS; i++) begin
            n = n + int'(s[i]);
        end
        return (n == 1);
    endfunction

endpackage

// File: rtl/sp_addr_route.sv
module sp_addr_route
    import scratch_pkg::*;
(
    input  logic [SETS_W-1:0] sets,
    input  sel_t              sel,
    output route_t            route
);

    addr_t gated [N_SETS];
    addr_t merged;
    logic  ok;

    genvar k;
    generate
        for (k = 0; k < N_SETS; k++) begin : g_gate
            assign gated[k] = sets[k*ADDR_W +: ADDR_W] & {ADDR_W{sel[k]}};
        end
    endgenerate

    always_comb begin
        merged = '0;
        for (int i = 0; i < N_SETS; i++) begin
            merged = merged | gated[i];
        end
    end

    assign ok = is_onehot(sel);

    always_comb begin
        route.err  = !ok;
        route.addr = ok ? merged : sets[ADDR_W-1:0];
    end

endmodule

// File: rtl/sp_write_ctrl.sv
module sp_write_ctrl
    import scratch_pkg::*;
(
    input  addr_t addr,
    input  lane_t lane_we,
    input  word_t wdata,
    output wreq_t req
);

    always_comb begin
        req.en   = |lane_we;
        req.addr = addr;
        req.data = wdata;
        req.mask = lane_to_mask(lane_we);
    end

endmodule

// File: rtl/sp_store.sv
module sp_store
    import scratch_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  wreq_t req,
    input  addr_t raddr,
    output word_t rword
);

    word_t mem [DEPTH];

    genvar w;
    generate
        for (w = 0; w < DEPTH; w++) begin : g_word
            always_ff @(posedge clk) begin
                if (rst) begin
                    mem[w] <= '0;
                end else if (req.en && (req.addr == addr_t'(w))) begin
                    mem[w] <= (mem[w] & ~req.mask) | (req.data & req.mask);
                end
            end
        end
    endgenerate

    assign rword = mem[raddr];

endmodule

// File: rtl/sp_regfile.sv
module sp_regfile
    import scratch_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [SETS_W-1:0]        addr_sets,
    input  logic [N_SETS-1:0]        set_sel,
    input  logic [N_LANES-1:0]       lane_we,
    input  logic [WORD_W-1:0]        wdata,
    input  logic                     out_en,
    output logic [WORD_W-1:0]        rdata,
    output logic                     sel_err
);

    route_t route;
    wreq_t  req;
    word_t  rword;

    sp_addr_route u_route (
        .sets  (addr_sets),
        .sel   (set_sel),
        .route (route)
    );

    sp_write_ctrl u_wctl (
        .addr    (route.addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .req     (req)
    );

    sp_store u_store (
        .clk   (clk),
        .rst   (rst),
        .req   (req),
        .raddr (route.addr),
        .rword (rword)
    );

    assign rdata   = out_en ? rword : '0;
    assign sel_err = route.err;

endmodule

// File: rtl/sp_regfile_chk.sv
module sp_regfile_chk
    import scratch_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [SETS_W-1:0]   addr_sets,
    input  logic [N_SETS-1:0]   set_sel,
    input  logic [N_LANES-1:0]  lane_we,
    input  logic [WORD_W-1:0]   wdata,
    input  logic                out_en,
    input  logic [WORD_W-1:0]   rdata,
    input  logic                sel_err
);

    a_r7_oe_low_zero: assert property (@(posedge clk) disable iff (rst)
        !out_en |-> (rdata == '0));

    a_r6_err_when_bad: assert property (@(posedge clk) disable iff (rst)
        ($countones(set_sel) != 1) |-> sel_err);

    a_r6_clean_when_onehot: assert property (@(posedge clk) disable iff (rst)
        ($countones(set_sel) == 1) |-> !sel_err);

    a_r3_idle_keeps_word: assert property (@(posedge clk) disable iff (rst)
        (out_en && $past(out_en) && !$past(rst) && ($past(lane_we) == '0)
         && $stable(addr_sets) && $stable(set_sel)) |-> $stable(rdata));

    a_r2_low_lane_write: assert property (@(posedge clk) disable iff (rst)
        (out_en && $past(out_en) && !$past(rst) && ($past(lane_we) == 2'b01)
         && $stable(addr_sets) && $stable(set_sel))
        |-> (rdata[7:0] == $past(wdata[7:0])) && (rdata[15:8] == $past(rdata[15:8])));

    a_r8_full_write_visible: assert property (@(posedge clk) disable iff (rst)
        (out_en && !$past(rst) && ($past(lane_we) == 2'b11)
         && $stable(addr_sets) && $stable(set_sel))
        |-> (rdata == $past(wdata)));

endmodule

bind sp_regfile sp_regfile_chk chk_i (.*);

// File: tb/sp_regfile_tb_top.sv
module sp_regfile_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] addr_sets;
    logic [3:0]  set_sel;
    logic [1:0]  lane_we;
    logic [15:0] wdata;
    logic        out_en;
    logic [15:0] rdata;
    logic        sel_err;

    logic [15:0] model [16];
    int errs = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    sp_regfile dut_i (
        .clk(clk), .rst(rst), .addr_sets(addr_sets), .set_sel(set_sel),
        .lane_we(lane_we), .wdata(wdata), .out_en(out_en),
        .rdata(rdata), .sel_err(sel_err)
    );

    task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Field k holds a, others hold distinct decoy addresses.
    task automatic place(input int k, input int a);
        for (int j = 0; j < 4; j++) begin
            addr_sets[j*4 +: 4] = (j == k) ? 4'(a) : 4'((a + 5*j + 3) % 16);
        end
        set_sel = 4'(1 << k);
    endtask

    task automatic do_write(input int k, input int a, input logic [1:0] lanes, input logic [15:0] d);
        @(negedge clk);
        place(k, a);
        lane_we = lanes;
        wdata = d;
        @(negedge clk);
        lane_we = 2'b00;
        if (lanes[1]) model[a][15:8] = d[15:8];
        if (lanes[0]) model[a][7:0]  = d[7:0];
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr_sets = '0; set_sel = 4'b0001; lane_we = '0; wdata = '0; out_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 16; i++) model[i] = '0;

        // R1 / R4: every word reads zero after reset, address changed without a clock
        for (int a = 0; a < 16; a++) begin
            place(a % 4, a);
            #1;
            check16("R1", rdata, 16'h0000);
            check16("R6", {15'b0, sel_err}, 16'h0000);
        end

        // R2 / R5 / R8: full-word writes through each field
        for (int a = 0; a < 16; a++) begin
            do_write(a % 4, a, 2'b11, 16'(16'hA55A ^ (a * 16'h1111)));
            place(a % 4, a);
            #1;
            check16("R8", rdata, model[a]);
        end
        // R5 / R4: read back through a different field
        for (int a = 0; a < 16; a++) begin
            place((a + 1) % 4, a);
            #1;
            check16("R5", rdata, model[a]);
        end

        // R2 / R3: lane writes
        for (int a = 0; a < 16; a++) begin
            do_write(a % 4, a, 2'b01, 16'(16'h3C00 + a));
            do_write((a + 2) % 4, a, 2'b10, 16'(16'h00C3 | (a << 12)));
            do_write((a + 3) % 4, a, 2'b00, 16'hFFFF);
        end
        for (int a = 0; a < 16; a++) begin
            place(a % 4, a);
            #1;
            check16("R3", rdata, model[a]);
        end

        // R6 / R5: sweep all select codes
        for (int s = 0; s < 16; s++) begin
            for (int j = 0; j < 4; j++) addr_sets[j*4 +: 4] = 4'((7 * j + s + 2) % 16);
            set_sel = 4'(s);
            #1;
            begin
                int n;
                int pick;
                n = $countones(4'(s));
                pick = 0;
                for (int j = 0; j < 4; j++) if (n == 1 && s[j]) pick = j;
                check16("R6", rdata, model[(7 * pick + s + 2) % 16]);
                check16("R6", {15'b0, sel_err}, (n == 1) ? 16'h0 : 16'h1);
            end
        end

        // R6: write with malformed select lands on field 0
        @(negedge clk);
        addr_sets = {4'd9, 4'd8, 4'd7, 4'd6};
        set_sel = 4'b0110;
        lane_we = 2'b11;
        wdata = 16'hBEEF;
        @(negedge clk);
        lane_we = 2'b00;
        model[6] = 16'hBEEF;
        for (int a = 6; a < 10; a++) begin
            place(0, a);
            #1;
            check16("R6", rdata, model[a]);
        end

        // R7: output enable gates rdata, writes still happen
        @(negedge clk);
        out_en = 1'b0;
        for (int a = 0; a < 4; a++) begin
            place(a, a);
            #1;
            check16("R7", rdata, 16'h0000);
        end
        do_write(1, 11, 2'b11, 16'h1234);
        place(1, 11);
        #1;
        check16("R7", rdata, 16'h0000);
        out_en = 1'b1;
        #1;
        check16("R7", rdata, 16'h1234);

        // R1: reset clears again
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int a = 0; a < 16; a++) begin
            place(3 - (a % 4), a);
            #1;
            check16("R1", rdata, 16'h0000);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule